// File: doc/BRIEF.md
# Memory Sleep Mode Controller

This block sits in front of a synchronous memory and manages its low-power state. An active-high sleep request arrives asynchronously to the clock. The block synchronises it, waits a fixed number of cycles, and then puts the memory front end to sleep. While asleep, every command, address, data and output-enable input is ignored. The forwarded address and write-data registers keep their contents, and the data bus output enable is held low so the bus floats.

When the request drops, the block opens a recovery window of a parameterised length. During this window only deselect and read commands reach the memory. A write is replaced by a deselect and flagged with a one-cycle error pulse. A burst-continue is also replaced by a deselect, but raises no error. If the request rises again during recovery, the block runs the entry delay once more and returns to sleep. Throughout the entry delay it keeps the recovery filtering in force.

The two-bit command encoding is: deselect 00, read 01, write 10, burst-continue 11.

Top module: `mslp_ctrl`

## Requirements
- R1: While reset is held, `state_o` is 00, `cmd_o` is 00 (deselect), `addr_o` and `wdata_o` are zero, and `wr_err_o` is 0.
- R2: In the normal state (`state_o` 00), every command, address and write-data value is forwarded one clock later, and `dq_oe_o` follows `dq_oe_i` in the same cycle.
- R3: The sleep request passes through a two-flop synchronizer. `state_o` becomes 01 (sleeping) two clocks after the synchronized request rises, which is the fourth rising edge after the pin rises.
- R4: While `state_o` is 01, `cmd_o` becomes 00 (deselect) on the next edge and `dq_oe_o` is 0, whatever the inputs are.
- R5: While asleep, `addr_o` and `wdata_o` keep the values they held when sleep was entered.
- R6: After the synchronized request falls during sleep, `state_o` reads 10 (recovering) for exactly REC_CYC clock cycles (4 by default) and then returns to 00.
- R7: While recovering, deselect (00) and read (01) are forwarded normally. A write (10) is forwarded as deselect, and `addr_o` and `wdata_o` hold their values.
- R8: A write blocked during recovery raises `wr_err_o` for the single cycle after that edge. `wr_err_o` is never raised outside a blocked write.
- R9: If the request rises again while recovering, `state_o` stays 10 and writes stay blocked until the entry delay has elapsed. Then `state_o` becomes 01.
- R10: With the default option, a burst-continue (11) during recovery is forwarded as deselect and does not raise `wr_err_o`.
- R11: `state_o` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| cmd_i | input | 2 | Incoming command (00 deselect, 01 read, 10 write, 11 burst-continue) |
| addr_i | input | AW | Incoming address |
| wdata_i | input | DW | Incoming write data |
| dq_oe_i | input | 1 | Requested data-bus output enable |
| cmd_o | output | 2 | Forwarded command |
| addr_o | output | AW | Forwarded address |
| wdata_o | output | DW | Forwarded write data |
| dq_oe_o | output | 1 | Gated data-bus output enable |
| state_o | output | 2 | 00 normal, 01 sleeping, 10 recovering |
| wr_err_o | output | 1 | One-cycle pulse for a write dropped in recovery |

## Verification
Two behaviours can land in the same cycle. A fresh sleep request can arrive while the recovery window is still counting. In that same window, a write can be presented that the block has to block and report. The bench raises the pin in the first recovery cycle and drives writes on every following edge. It then checks three things on each edge: the error pulse fires, the status holds at 10 until the fourth edge, and the status then goes straight to 01 with no normal cycle in between.

// File: rtl/mslp_pkg.sv
package mslp_pkg;

   typedef enum logic [1:0] {
      CMD_DESEL = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_CONT  = 2'b11
   } mslp_cmd_e;

   typedef enum logic [2:0] {
      PH_RUN     = 3'd0,
      PH_ENTER   = 3'd1,
      PH_SLEEP   = 3'd2,
      PH_RECOV   = 3'd3,
      PH_ENTER_R = 3'd4
   } mslp_phase_e;

   localparam logic [1:0] STAT_NORMAL = 2'b00;
   localparam logic [1:0] STAT_SLEEP  = 2'b01;
   localparam logic [1:0] STAT_RECOV  = 2'b10;

endpackage

// File: rtl/mslp_sync.sv
module mslp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   initial begin
      assert (STAGES >= 2) else $fatal(1, "mslp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/mslp_fsm.sv
module mslp_fsm
   import mslp_pkg::*;
#(
   parameter int ENTRY_CYC = 2,
   parameter int REC_CYC   = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_sync_i,
   output mslp_phase_e phase_o,
   output logic [1:0]  state_o
);

   localparam int MAXC = (ENTRY_CYC > REC_CYC) ? ENTRY_CYC : REC_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 2);
   localparam logic [CW-1:0] REC_LAST   = CW'(REC_CYC - 1);

   initial begin
      assert (ENTRY_CYC >= 2) else $fatal(1, "mslp_fsm: ENTRY_CYC must be at least 2");
      assert (REC_CYC >= 1)   else $fatal(1, "mslp_fsm: REC_CYC must be at least 1");
   end

   mslp_phase_e       phase_q, phase_d;
   logic [CW-1:0]     cnt_q, cnt_d;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      unique case (phase_q)
         PH_RUN: begin
            if (req_sync_i) begin
               phase_d = PH_ENTER;
               cnt_d   = '0;
            end
         end
         PH_ENTER, PH_ENTER_R: begin
            if (cnt_q == ENTRY_LAST) begin
               phase_d = PH_SLEEP;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_SLEEP: begin
            if (!req_sync_i) begin
               phase_d = PH_RECOV;
               cnt_d   = '0;
            end
         end
         PH_RECOV: begin
            if (req_sync_i) begin
               phase_d = PH_ENTER_R;
               cnt_d   = '0;
            end else if (cnt_q == REC_LAST) begin
               phase_d = PH_RUN;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            phase_d = PH_RUN;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_RUN;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   always_comb begin
      unique case (phase_q)
         PH_SLEEP:             state_o = STAT_SLEEP;
         PH_RECOV, PH_ENTER_R: state_o = STAT_RECOV;
         default:              state_o = STAT_NORMAL;
      endcase
   end

   assign phase_o = phase_q;

   // R3: sleep is reached only through an entry phase
   p_sleep_via_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SLEEP && $past(phase_q) != PH_SLEEP)
         |-> ($past(phase_q) == PH_ENTER || $past(phase_q) == PH_ENTER_R));

   // R6: the recovery counter never passes its last value
   p_rec_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RECOV) |-> (cnt_q <= REC_LAST));

   // R11: status encoding stays within the three legal codes
   p_status_enc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'b11);

endmodule

// File: rtl/mslp_gate.sv
module mslp_gate
   import mslp_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter bit BLOCK_CONT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  mslp_phase_e   phase_i,
   input  logic [1:0]    cmd_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          oe_i,
   output logic [1:0]    cmd_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   output logic          oe_o,
   output logic          wr_err_o
);

   initial begin
      assert (AW >= 1) else $fatal(1, "mslp_gate: AW must be positive");
      assert (DW >= 1) else $fatal(1, "mslp_gate: DW must be positive");
   end

   logic          asleep, filtering, is_wr, blocked;
   logic [1:0]    cmd_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          err_q;

   assign asleep    = (phase_i == PH_SLEEP);
   assign filtering = (phase_i == PH_RECOV) || (phase_i == PH_ENTER_R);
   assign is_wr     = (cmd_i == CMD_WRITE);

   generate
      if (BLOCK_CONT) begin : g_block_cont
         assign blocked = filtering && (is_wr || (cmd_i == CMD_CONT));
      end else begin : g_pass_cont
         assign blocked = filtering && is_wr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= CMD_DESEL;
         addr_q  <= '0;
         wdata_q <= '0;
         err_q   <= 1'b0;
      end else if (asleep || blocked) begin
         cmd_q   <= CMD_DESEL;
         err_q   <= blocked && is_wr;
      end else begin
         cmd_q   <= cmd_i;
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
         err_q   <= 1'b0;
      end
   end

   assign cmd_o    = cmd_q;
   assign addr_o   = addr_q;
   assign wdata_o  = wdata_q;
   assign wr_err_o = err_q;
   assign oe_o     = oe_i && !asleep;

   // R4: nothing but deselect leaves while asleep
   p_sleep_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |=> (cmd_o == CMD_DESEL));

   // R4: bus floats while asleep
   p_sleep_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !oe_o);

   // R5: forwarded address and data are preserved through sleep
   p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |=> ($stable(addr_o) && $stable(wdata_o)));

   // R7: no write reaches the memory during recovery
   p_rec_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      filtering |=> (cmd_o != CMD_WRITE));

   // R8: error pulse only follows a blocked write
   p_err_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err_o |-> $past(filtering && cmd_i == CMD_WRITE));

endmodule

// File: rtl/mslp_ctrl.sv
module mslp_ctrl
   import mslp_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ENTRY_CYC   = 2,
   parameter int REC_CYC     = 4,
   parameter bit BLOCK_CONT  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_req_i,
   input  logic [1:0]    cmd_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          dq_oe_i,
   output logic [1:0]    cmd_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   output logic          dq_oe_o,
   output logic [1:0]    state_o,
   output logic          wr_err_o
);

   logic        req_sync;
   mslp_phase_e phase;

   mslp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sleep_req_i),
      .sync_o  (req_sync)
   );

   mslp_fsm #(.ENTRY_CYC(ENTRY_CYC), .REC_CYC(REC_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_sync_i (req_sync),
      .phase_o    (phase),
      .state_o    (state_o)
   );

   mslp_gate #(.AW(AW), .DW(DW), .BLOCK_CONT(BLOCK_CONT)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase_i  (phase),
      .cmd_i    (cmd_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .oe_i     (dq_oe_i),
      .cmd_o    (cmd_o),
      .addr_o   (addr_o),
      .wdata_o  (wdata_o),
      .oe_o     (dq_oe_o),
      .wr_err_o (wr_err_o)
   );

   // R9: a write is never forwarded in the cycle after status reads recovering
   p_top_rec_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == STAT_RECOV) |=> (cmd_o != 2'b10));

endmodule

// File: tb/sim_mslp_ctrl.sv
module sim_mslp_ctrl;

   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          sleep_req_i;
   logic [1:0]    cmd_i;
   logic [AW-1:0] addr_i;
   logic [DW-1:0] wdata_i;
   logic          dq_oe_i;
   logic [1:0]    cmd_o;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] wdata_o;
   logic          dq_oe_o;
   logic [1:0]    state_o;
   logic          wr_err_o;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   mslp_ctrl #(.AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i),
      .cmd_i(cmd_i), .addr_i(addr_i), .wdata_i(wdata_i), .dq_oe_i(dq_oe_i),
      .cmd_o(cmd_o), .addr_o(addr_o), .wdata_o(wdata_o), .dq_oe_o(dq_oe_o),
      .state_o(state_o), .wr_err_o(wr_err_o)
   );

   // vector: {cmd[1:0], oe, addr[15:0], wdata[15:0]}
   localparam int VN = 8;
   localparam logic [34:0] VEC [0:VN-1] = '{
      {2'b01, 1'b1, 16'h1000, 16'hA001},
      {2'b10, 1'b0, 16'h1004, 16'hB002},
      {2'b11, 1'b1, 16'h1008, 16'hC003},
      {2'b00, 1'b0, 16'h100C, 16'hD004},
      {2'b10, 1'b1, 16'hFFFF, 16'h0000},
      {2'b01, 1'b0, 16'h0000, 16'hFFFF},
      {2'b11, 1'b0, 16'h5A5A, 16'hA5A5},
      {2'b10, 1'b1, 16'h0001, 16'h8000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] c, input logic [15:0] a, input logic [15:0] d, input logic oe);
      cmd_i = c; addr_i = a; wdata_i = d; dq_oe_i = oe;
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sleep_req_i = 1'b0;
      drive(2'b10, 16'h7777, 16'h3333, 1'b1);
      repeat (3) nxt();
      // R1 reset state
      chk("R1 state", 32'(state_o), 32'h0);
      chk("R1 cmd", 32'(cmd_o), 32'h0);
      chk("R1 addr", 32'(addr_o), 32'h0);
      chk("R1 wdata", 32'(wdata_o), 32'h0);
      chk("R1 err", 32'(wr_err_o), 32'h0);
      rst_n = 1'b1;
      drive(2'b00, 16'h0, 16'h0, 1'b0);
      nxt();

      // R2 table-driven forwarding in the normal state
      for (int i = 0; i < VN; i++) begin
         drive(VEC[i][34:33], VEC[i][31:16], VEC[i][15:0], VEC[i][32]);
         #1;
         chk("R2 oe", 32'(dq_oe_o), 32'(VEC[i][32]));
         nxt();
         chk("R2 cmd", 32'(cmd_o), 32'(VEC[i][34:33]));
         chk("R2 addr", 32'(addr_o), 32'(VEC[i][31:16]));
         chk("R2 wdata", 32'(wdata_o), 32'(VEC[i][15:0]));
         chk("R2 state", 32'(state_o), 32'h0);
      end

      // R3 entry latency: pin rises, sleep after the fourth edge
      drive(2'b01, 16'h00A1, 16'h00D1, 1'b1);
      sleep_req_i = 1'b1;
      nxt();
      drive(2'b00, 16'h00A1, 16'h00D1, 1'b1);
      chk("R3 state e1", 32'(state_o), 32'h0);
      nxt();
      chk("R3 state e2", 32'(state_o), 32'h0);
      nxt();
      chk("R3 state e3", 32'(state_o), 32'h0);
      nxt();
      chk("R3 state e4", 32'(state_o), 32'h1);

      // R4 / R5 inputs ignored while asleep
      drive(2'b10, 16'h00A2, 16'h00D2, 1'b1);
      #1;
      chk("R4 oe", 32'(dq_oe_o), 32'h0);
      nxt();
      chk("R4 cmd", 32'(cmd_o), 32'h0);
      chk("R5 addr", 32'(addr_o), 32'h00A1);
      chk("R5 wdata", 32'(wdata_o), 32'h00D1);

      // R6 recovery window
      sleep_req_i = 1'b0;
      nxt();
      chk("R6 still asleep", 32'(state_o), 32'h1);
      nxt();
      chk("R5 addr late", 32'(addr_o), 32'h00A1);
      nxt();
      chk("R6 recov start", 32'(state_o), 32'h2);

      // R7 / R8 blocked write
      drive(2'b10, 16'h00A3, 16'h00D3, 1'b1);
      nxt();
      chk("R7 cmd", 32'(cmd_o), 32'h0);
      chk("R7 addr", 32'(addr_o), 32'h00A1);
      chk("R8 err", 32'(wr_err_o), 32'h1);
      chk("R6 recov 2", 32'(state_o), 32'h2);
      drive(2'b01, 16'h00A4, 16'h00D4, 1'b1);
      #1;
      chk("R7 oe", 32'(dq_oe_o), 32'h1);
      nxt();
      chk("R7 read cmd", 32'(cmd_o), 32'h1);
      chk("R7 read addr", 32'(addr_o), 32'h00A4);
      chk("R8 pulse end", 32'(wr_err_o), 32'h0);
      chk("R6 recov 3", 32'(state_o), 32'h2);

      // R10 burst-continue blocked silently
      drive(2'b11, 16'h00A5, 16'h00D5, 1'b0);
      nxt();
      chk("R10 cmd", 32'(cmd_o), 32'h0);
      chk("R10 err", 32'(wr_err_o), 32'h0);
      chk("R10 addr", 32'(addr_o), 32'h00A4);
      chk("R6 recov 4", 32'(state_o), 32'h2);
      drive(2'b00, 16'h00A5, 16'h00D5, 1'b0);
      nxt();
      chk("R6 back to normal", 32'(state_o), 32'h0);

      // R2 after recovery writes flow again
      drive(2'b10, 16'h00A6, 16'h00D6, 1'b0);
      nxt();
      chk("R2 post write", 32'(cmd_o), 32'h2);
      chk("R2 post addr", 32'(addr_o), 32'h00A6);

      // R9 re-entry while recovering, combined with blocked writes
      drive(2'b00, 16'h00A6, 16'h00D6, 1'b0);
      sleep_req_i = 1'b1;
      repeat (4) nxt();
      chk("R9 asleep again", 32'(state_o), 32'h1);
      sleep_req_i = 1'b0;
      repeat (3) nxt();
      chk("R9 recov", 32'(state_o), 32'h2);
      sleep_req_i = 1'b1;
      drive(2'b10, 16'h00A7, 16'h00D7, 1'b1);
      nxt();
      chk("R9 err 1", 32'(wr_err_o), 32'h1);
      chk("R9 state 1", 32'(state_o), 32'h2);
      nxt();
      chk("R9 err 2", 32'(wr_err_o), 32'h1);
      chk("R9 state 2", 32'(state_o), 32'h2);
      nxt();
      chk("R9 entry state", 32'(state_o), 32'h2);
      chk("R9 entry cmd", 32'(cmd_o), 32'h0);
      nxt();
      chk("R9 sleep", 32'(state_o), 32'h1);
      chk("R9 err entry", 32'(wr_err_o), 32'h1);
      chk("R9 addr held", 32'(addr_o), 32'h00A6);

      // R11 status stays legal through a full exit
      sleep_req_i = 1'b0;
      drive(2'b00, 16'h0, 16'h0, 1'b0);
      for (int k = 0; k < 10; k++) begin
         nxt();
         chk("R11 legal", 32'(state_o == 2'b11), 32'h0);
      end
      chk("R6 final normal", 32'(state_o), 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule